// File: doc/BRIEF.md
# Manchester II frame encoder

This block serialises one parallel data word into a Manchester II frame for a time-division multiplexed serial bus. The frame opens with a three-bit-period sync field that breaks the Manchester rule, so a receiver can find it. The data word follows, most significant bit first, with every bit cell split into two half-cells. A single parity bit closes the frame. The clock runs at twice the bit rate, so each clock period carries exactly one half-cell.

The host presents a word, a length, a sync-type select and a parity-mode select, and pulses a start strobe while the block is idle. The block captures all of these on the accepting edge and drives a complementary pair of line outputs with a transmit enable until the last half-cell has been sent. It then pulses a one-clock done flag. The word-length input is meant to be shared with a companion decoder. Apart from that and reset, the encoder needs nothing from the decoder.

Top module: `manenc_frame_tx`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, tx_en_o, line_p_o and line_n_o are all 0. This also applies when reset arrives in the middle of a frame, with no clock edge needed.
- R2: While busy_o is 0, tx_en_o, line_p_o and line_n_o are 0 for any input values.
- R3: A start_i seen high at a rising edge while busy_o is 0 starts a frame. From that edge on, busy_o is 1 and half-cell 0 of the frame is on the line.
- R4: start_i has no effect while busy_o is 1. The running frame continues unchanged and ends at its original cycle.
- R5: The sync field lasts 6 half-cells. With sync_cmd_i = 1, line_p_o is 1,1,1,0,0,0. With sync_cmd_i = 0, it is 0,0,0,1,1,1.
- R6: After sync, the data bits are sent starting from data_i[N-1] and ending at data_i[0], where N is the effective length. A 1 goes out as line_p_o high then low, and a 0 as low then high.
- R7: The effective length N is word_len_i clamped to the range 2..28. A frame occupies 2N+8 half-cells.
- R8: The parity cell follows the data and is encoded like a data bit. With parity_odd_i = 0, the parity bit is the XOR of the N data bits (an even total count of ones). With parity_odd_i = 1, it is the inverse of that XOR.
- R9: busy_o stays 1 through the final parity half-cell. On the next edge it falls, and done_o is 1 for exactly one clock.
- R10: While busy_o is 1, tx_en_o is 1 and line_n_o is the complement of line_p_o.
- R11: data_i, word_len_i, sync_cmd_i and parity_odd_i are captured at the accepting edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cell clock (twice the bit rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request, honoured only while idle |
| data_i | input | 28 | Data word; the low N bits are sent |
| word_len_i | input | 5 | Requested data bit count, clamped to 2..28 |
| sync_cmd_i | input | 1 | 1: command/status sync, 0: data sync |
| parity_odd_i | input | 1 | 1: odd parity, 0: even parity |
| line_p_o | output | 1 | True line level |
| line_n_o | output | 1 | Complement line level |
| tx_en_o | output | 1 | Transmitter enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse after the last half-cell |

## Verification
The bench drives frames at the shortest length, at the longest length, and with word_len_i values below and above the legal range. A design that failed to clamp these would send frames of the wrong duration or read bits outside the word. Both sync types and both parity modes appear with all-zero, all-one and alternating data, so a reversed sync, an inverted parity sense or a wrong bit order shows up as a miscompared half-cell. One frame is hit mid-way by a second start together with new data and new settings. A design that re-armed on that start or sampled its inputs live would corrupt the tail of the frame or move the done pulse. A reset in the middle of a frame must silence the line at once, or the line would be left driven.

// File: rtl/manenc_pkg.sv
package manenc_pkg;
  localparam int unsigned SYNC_HALVES = 6;   // three bit periods
  localparam int unsigned TAIL_HALVES = 2;   // parity cell

  function automatic int unsigned frame_halves(int unsigned max_bits);
    return SYNC_HALVES + 2 * max_bits + TAIL_HALVES;
  endfunction
endpackage

// File: rtl/manenc_parity.sv
module manenc_parity #(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                odd_i,
  output logic                par_o
);
  logic [MAX_BITS-1:0] mask;

  for (genvar k = 0; k < MAX_BITS; k++) begin : g_mask
    assign mask[k] = (LEN_W'(k) < len_i);
  end

  assign par_o = (^(data_i & mask)) ^ odd_i;
endmodule

// File: rtl/manenc_frame_build.sv
module manenc_frame_build
  import manenc_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1),
  parameter int unsigned HALVES   = frame_halves(MAX_BITS)
) (
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                sync_cmd_i,
  input  logic                par_i,
  output logic [HALVES-1:0]   pat_o
);
  localparam logic [SYNC_HALVES-1:0] SYNC_CMD = {{(SYNC_HALVES/2){1'b1}}, {(SYNC_HALVES/2){1'b0}}};

  assign pat_o[HALVES-1 -: SYNC_HALVES] = sync_cmd_i ? SYNC_CMD : ~SYNC_CMD;

  // slot j carries data bit N-1-j, slot N carries parity; later slots are never shifted out
  for (genvar j = 0; j <= MAX_BITS; j++) begin : g_slot
    logic slot;
    always_comb begin
      if (LEN_W'(j) < len_i) slot = data_i[len_i - LEN_W'(j + 1)];
      else                   slot = par_i;
    end
    assign pat_o[HALVES-1-SYNC_HALVES-2*j] = slot;
    assign pat_o[HALVES-2-SYNC_HALVES-2*j] = ~slot;
  end
endmodule

// File: rtl/manenc_shifter.sv
module manenc_shifter
  import manenc_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1),
  parameter int unsigned HALVES   = frame_halves(MAX_BITS),
  parameter int unsigned CNT_W    = $clog2(HALVES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALVES-1:0] pat_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              level_o
);
  logic [HALVES-1:0] pat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  total;

  assign total = CNT_W'(SYNC_HALVES + TAIL_HALVES) + (CNT_W'(len_i) << 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          pat_q  <= pat_i;
          cnt_q  <= total;
          busy_q <= 1'b1;
        end
      end else begin
        pat_q <= pat_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign level_o = pat_q[HALVES-1];
endmodule

// File: rtl/manenc_frame_tx.sv
module manenc_frame_tx
  import manenc_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned MIN_BITS = 2,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    word_len_i,
  input  logic                sync_cmd_i,
  input  logic                parity_odd_i,
  output logic                line_p_o,
  output logic                line_n_o,
  output logic                tx_en_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned HALVES = frame_halves(MAX_BITS);

  logic [LEN_W-1:0]  len_eff;
  logic              par;
  logic [HALVES-1:0] pat;
  logic              level;

  always_comb begin
    if (word_len_i < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
    else if (word_len_i > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
    else                                    len_eff = word_len_i;
  end

  manenc_parity #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_par (
    .data_i (data_i),
    .len_i  (len_eff),
    .odd_i  (parity_odd_i),
    .par_o  (par)
  );

  manenc_frame_build #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .HALVES(HALVES)) u_build (
    .data_i     (data_i),
    .len_i      (len_eff),
    .sync_cmd_i (sync_cmd_i),
    .par_i      (par),
    .pat_o      (pat)
  );

  manenc_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .HALVES(HALVES)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .pat_i   (pat),
    .len_i   (len_eff),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .level_o (level)
  );

  assign tx_en_o  = busy_o;
  assign line_p_o = busy_o & level;
  assign line_n_o = busy_o & ~level;
endmodule

// File: rtl/manenc_frame_tx_chk.sv
module manenc_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sync_cmd_i,
  input logic line_p_o,
  input logic line_n_o,
  input logic tx_en_o,
  input logic busy_o,
  input logic done_o
);
  logic [7:0] hcnt;
  logic       sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt   <= '0;
      sync_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      hcnt   <= '0;
      sync_q <= sync_cmd_i;
    end else if (busy_o) begin
      hcnt <= hcnt + 8'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !tx_en_o && !line_p_o && !line_n_o));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_en_o && !line_p_o && !line_n_o));

  p_start_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_sync_head_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hcnt < 8'd3) |-> (line_p_o == sync_q));

  p_sync_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hcnt >= 8'd3 && hcnt < 8'd6) |-> (line_p_o != sync_q));

  p_mid_cell_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hcnt >= 8'd7 && hcnt[0]) |-> (line_p_o != $past(line_p_o)));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_line_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tx_en_o && (line_p_o ^ line_n_o)));
endmodule

bind manenc_frame_tx manenc_frame_tx_chk u_chk (.*);

// File: tb/manenc_frame_tx_test.sv
module manenc_frame_tx_test;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {data[27:0], word_len[4:0], sync_cmd, parity_odd}
  localparam logic [34:0] VEC [NVEC] = '{
    {28'h0000002, 5'd2,  1'b1, 1'b0},
    {28'hA5A5A5A, 5'd28, 1'b0, 1'b1},
    {28'hFFFFFFF, 5'd28, 1'b1, 1'b0},
    {28'h0000000, 5'd16, 1'b0, 1'b1},
    {28'h0001234, 5'd16, 1'b1, 1'b1},
    {28'h00000FF, 5'd0,  1'b0, 1'b0},
    {28'h5555555, 5'd31, 1'b1, 1'b0},
    {28'h000001F, 5'd5,  1'b0, 1'b0}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [27:0] data_i = '0;
  logic [4:0]  word_len_i = 5'd2;
  logic        sync_cmd_i = 1'b0, parity_odd_i = 1'b0;
  logic        line_p_o, line_n_o, tx_en_o, busy_o, done_o;

  int n_chk = 0, n_err = 0;

  manenc_frame_tx uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < 2) ? 2 : (l > 28) ? 28 : l;
  endfunction

  function automatic bit exp_level(input int k, input logic [27:0] d, input int n,
                                   input bit cmd, input bit odd);
    bit b, par;
    int j;
    if (k < 6) return cmd ? (k < 3) : (k >= 3);
    par = odd;
    for (int i = 0; i < n; i++) par ^= d[i];
    j = (k - 6) / 2;
    b = (j < n) ? d[n-1-j] : par;
    return ((k - 6) % 2 == 0) ? b : !b;
  endfunction

  task automatic run_frame(input logic [27:0] d, input logic [4:0] len, input bit cmd,
                           input bit odd, input bit disturb);
    int n = eff_len(int'(len));
    int halves = 2 * n + 8;
    logic [5:0]  s_act = '0, s_exp = '0;
    logic [55:0] d_act = '0, d_exp = '0;
    logic [1:0]  p_act = '0, p_exp = '0;
    bit pair_ok = 1'b1, busy_ok = 1'b1;
    @(negedge clk_i);
    data_i = d; word_len_i = len; sync_cmd_i = cmd; parity_odd_i = odd; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < halves; k++) begin
      bit e = exp_level(k, d, n, cmd, odd);
      if (!busy_o) busy_ok = 1'b0;
      if (!tx_en_o || (line_n_o != !line_p_o)) pair_ok = 1'b0;
      if (k < 6)           begin s_act = {s_act[4:0], line_p_o}; s_exp = {s_exp[4:0], e}; end
      else if (k < 6 + 2*n) begin d_act = {d_act[54:0], line_p_o}; d_exp = {d_exp[54:0], e}; end
      else                 begin p_act = {p_act[0], line_p_o}; p_exp = {p_exp[0], e}; end
      if (disturb && k == 10) begin
        start_i = 1'b1; data_i = ~d; word_len_i = 5'd5;
        sync_cmd_i = !cmd; parity_odd_i = !odd;
      end
      if (disturb && k == 11) start_i = 1'b0;
      @(negedge clk_i);
    end
    check(s_act == s_exp, "R5", "sync half-cells", s_act, s_exp);
    check(d_act == d_exp, disturb ? "R11" : "R6", "data half-cells", d_act, d_exp);
    check(p_act == p_exp, "R8", "parity half-cells", p_act, p_exp);
    check(pair_ok, "R10", "line pair/tx_en while busy", pair_ok, 1);
    check(busy_ok, disturb ? "R4" : "R7", "busy through frame length", busy_ok, 1);
    check(!busy_o && done_o, "R9", "busy low, done high after last half", {busy_o, done_o}, 2'b01);
    @(negedge clk_i);
    check(!done_o && !line_p_o && !line_n_o && !tx_en_o, "R9", "done one clock, idle after",
          {done_o, tx_en_o, line_p_o, line_n_o}, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({busy_o, done_o, tx_en_o, line_p_o, line_n_o} == 0, "R1", "outputs in reset",
          {busy_o, done_o, tx_en_o, line_p_o, line_n_o}, 0);
    rst_ni = 1'b1;
    // R2: idle with busy inputs but no start
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      data_i = 28'(i * 32'h1357_9BD); sync_cmd_i = i[0]; parity_odd_i = i[1];
      word_len_i = 5'(i * 5);
    end
    @(negedge clk_i);
    check({busy_o, tx_en_o, line_p_o, line_n_o} == 0, "R2", "idle line quiet",
          {busy_o, tx_en_o, line_p_o, line_n_o}, 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][34:7], VEC[v][6:2], VEC[v][1], VEC[v][0], 1'b0);

    // R3 R4 R11: second start and new settings mid-frame
    run_frame(28'h0ABCDEF, 5'd20, 1'b1, 1'b0, 1'b1);

    // R3: busy right after accept
    @(negedge clk_i);
    data_i = 28'h3; word_len_i = 5'd2; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o && tx_en_o, "R3", "busy after accepting edge", busy_o, 1);
    repeat (4) @(negedge clk_i);
    // R1: asynchronous reset mid-frame
    #1 rst_ni = 1'b0;
    #1;
    check({busy_o, done_o, tx_en_o, line_p_o, line_n_o} == 0, "R1", "mid-frame reset",
          {busy_o, done_o, tx_en_o, line_p_o, line_n_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && !done_o, "R1", "stays idle after reset release", {busy_o, done_o}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule